// File: doc/BRIEF.md
# Repeater Link Power-State Controller

This block sets the power state of one channel pair in a signal-conditioning repeater for a 5 Gbit/s serial link. It makes its choice from what it can observe on the bus: how long the input has been electrically idle, low-frequency wake bursts, the results of receiver-termination probes, and the chip enable. It never decodes link-layer power commands. The block drives the data-path enable, the common-mode bias hold, the termination enable, a one-cycle request to probe for a far-end receiver termination, and a ready flag.

There are three top-level conditions: off (shutdown), low-power and running. Low-power has two flavours. In the first, no partner is attached and the bias is released. In the second, a partner is attached but the link sleeps, and the bias is held. Two transient states sit between them: one lets the analog circuits settle after enable, and one is the exit delay after a wake burst. Every interval counts ticks of one shared prescaler, and each interval length is a parameter given in ticks. With the default tick of 500 clock cycles (10 µs at 50 MHz), the idle wait is 300 ms, the settle time is 20 ms, the reconfiguration hold is 100 ms and the wake delay is 10 µs.

Top module: `redrv_pwr_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released with chip_en low, dp_en, cm_hold, term_en, rxdet_req and ready are all 0.
- R2: Whenever chip_en is sampled low, the controller is in shutdown from the next cycle on, with dp_en, cm_hold, term_en and ready all 0, whatever the bus inputs show.
- R3: After chip_en rises, ready stays 0 and term_en is 1 for SETTLE_TICKS ticks. The controller then enters the unconnected low-power state and ready becomes 1.
- R4: In the running state, dp_en, cm_hold and term_en are all 1 and rxdet_req is never raised.
- R5: The running state is left for the connected low-power state only after sq_idle has been 1 for IDLE_TICKS consecutive ticks (the value is clamped to IDLE_LIMIT). Any cycle with sq_idle at 0 restarts this wait.
- R6: In the connected low-power state, cm_hold is 1 and dp_en is 0. A pulse on lfps_det starts an exit delay of WAKE_TICKS ticks, with dp_en still 0 and cm_hold 1, and the running state follows the delay.
- R7: In the unconnected low-power state, cm_hold is 0 and dp_en is 0, and a pulse on lfps_det has no effect.
- R8: In both low-power states, rxdet_req is raised for exactly one cycle once every POLL_TICKS ticks.
- R9: A result pulse on rxdet_done with rxdet_found=1 moves the unconnected state to the connected one. With rxdet_found=0, it moves the connected state to the unconnected one and releases cm_hold.
- R10: Any change of the cfg_sel value drops ready to 0 from the next cycle on, for RECFG_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Chip enable; low forces shutdown |
| sq_idle | input | 1 | 1 while the squelch detector reports electrical idle |
| lfps_det | input | 1 | One-cycle pulse when a low-frequency wake burst is seen |
| rxdet_done | input | 1 | One-cycle pulse when a termination probe result is valid |
| rxdet_found | input | 1 | Probe result: 1 means far-end termination present |
| cfg_sel | input | CFG_W | Equalizer and de-emphasis settings; watched for changes |
| dp_en | output | 1 | Enables the data path (equalizer and line driver) |
| cm_hold | output | 1 | Holds the DC common-mode bias on the lanes |
| term_en | output | 1 | 1 enables terminations, 0 puts them at high impedance |
| rxdet_req | output | 1 | One-cycle request to start a termination probe |
| ready | output | 1 | Settings and power state are stable |

## Verification
The bench builds the controller with a tick of 4 clocks, an idle wait of 6 ticks against a limit of 8, a 2-tick wake delay, a 5-tick settle time, a 7-tick reconfiguration hold and a 3-tick probe period. With these values every interval runs out within a few tens of cycles. The full path from enable through settle, probing, the connected sleep, wake, running, re-idle and loss of partner can then be walked many times. The timing windows can be checked against the uncertain phase of the tick, and so can the restart of the idle wait after a single busy cycle.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [2:0] {
    ST_DEEP   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_PS_NC  = 3'd2,
    ST_PS_CN  = 3'd3,
    ST_WAKE   = 3'd4,
    ST_ACTIVE = 3'd5
  } pstate_e;

  typedef struct packed {
    logic dp;
    logic cm;
    logic term;
  } drv_t;

  function automatic drv_t drive_of(pstate_e s);
    drv_t d;
    case (s)
      ST_SETTLE: d = '{dp: 1'b0, cm: 1'b0, term: 1'b1};
      ST_PS_NC:  d = '{dp: 1'b0, cm: 1'b0, term: 1'b1};
      ST_PS_CN:  d = '{dp: 1'b0, cm: 1'b1, term: 1'b1};
      ST_WAKE:   d = '{dp: 1'b0, cm: 1'b1, term: 1'b1};
      ST_ACTIVE: d = '{dp: 1'b1, cm: 1'b1, term: 1'b1};
      default:   d = '{dp: 1'b0, cm: 1'b0, term: 1'b0};
    endcase
    return d;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rpc_tick_gen.sv
module rpc_tick_gen #(
  parameter int TICK_DIV = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(TICK_DIV - 1)) || (TICK_DIV <= 1);

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

endmodule

// File: rtl/rpc_timer.sv
module rpc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         dec_en;

  assign dec_en = tick && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = len;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/rpc_state_fsm.sv
module rpc_state_fsm
  import rpc_pkg::*;
#(
  parameter int TW           = 16,
  parameter int IDLE_TICKS   = 300,
  parameter int WAKE_TICKS   = 1,
  parameter int SETTLE_TICKS = 20,
  parameter int POLL_TICKS   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en,
  input  logic          sq_idle,
  input  logic          lfps_det,
  input  logic          rxdet_done,
  input  logic          rxdet_found,
  input  logic          tmr_done,
  input  logic          poll_done,
  output pstate_e       state_o,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_len,
  output logic          poll_load,
  output logic [TW-1:0] poll_len,
  output logic          rxdet_req
);
  pstate_e st_q, st_d;
  logic    in_ps, poll_fire, req_q, req_d;

  // next-state decision from bus conditions only
  always_comb begin
    st_d = st_q;
    if (!chip_en) begin
      st_d = ST_DEEP;
    end else begin
      case (st_q)
        ST_DEEP:   st_d = ST_SETTLE;
        ST_SETTLE: if (tmr_done) st_d = ST_PS_NC;
        ST_PS_NC:  if (rxdet_done && rxdet_found) st_d = ST_PS_CN;
        ST_PS_CN: begin
          if (lfps_det)                         st_d = ST_WAKE;
          else if (rxdet_done && !rxdet_found)  st_d = ST_PS_NC;
        end
        ST_WAKE:   if (tmr_done) st_d = ST_ACTIVE;
        ST_ACTIVE: if (sq_idle && tmr_done) st_d = ST_PS_CN;
        default:   st_d = ST_DEEP;
      endcase
    end
  end

  // shared interval timer: reloaded on every state change, and by
  // bus activity while running
  always_comb begin
    tmr_load = (st_d != st_q) || ((st_q == ST_ACTIVE) && !sq_idle);
    case (st_d)
      ST_SETTLE: tmr_len = TW'(SETTLE_TICKS);
      ST_WAKE:   tmr_len = TW'(WAKE_TICKS);
      ST_ACTIVE: tmr_len = TW'(IDLE_TICKS);
      default:   tmr_len = '0;
    endcase
  end

  // termination probe pacing in the low-power states
  assign in_ps     = (st_q == ST_PS_NC) || (st_q == ST_PS_CN);
  assign poll_fire = in_ps && poll_done;
  assign poll_load = !in_ps || poll_fire;
  assign poll_len  = TW'(POLL_TICKS);
  assign req_d     = poll_fire && (st_d == st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_DEEP;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
    end
  end

  assign state_o   = st_q;
  assign rxdet_req = req_q;

  a_r2_off_forces_deep: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (st_q == ST_DEEP));

  a_r5_busy_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && chip_en && !sq_idle) |=> (st_q == ST_ACTIVE));

  a_r6_lfps_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PS_CN && chip_en && lfps_det) |=> (st_q == ST_WAKE));

  a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rxdet_req |=> !rxdet_req);

endmodule

// File: rtl/redrv_pwr_ctrl.sv
module redrv_pwr_ctrl
  import rpc_pkg::*;
#(
  parameter int TICK_DIV     = 500,
  parameter int IDLE_TICKS   = 30000,
  parameter int IDLE_LIMIT   = 40000,
  parameter int WAKE_TICKS   = 1,
  parameter int SETTLE_TICKS = 2000,
  parameter int RECFG_TICKS  = 10000,
  parameter int POLL_TICKS   = 1000,
  parameter int CFG_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             sq_idle,
  input  logic             lfps_det,
  input  logic             rxdet_done,
  input  logic             rxdet_found,
  input  logic [CFG_W-1:0] cfg_sel,
  output logic             dp_en,
  output logic             cm_hold,
  output logic             term_en,
  output logic             rxdet_req,
  output logic             ready
);
  localparam int IDLE_EFF = (IDLE_TICKS > IDLE_LIMIT) ? IDLE_LIMIT : IDLE_TICKS;
  localparam int MAXT     = max2(max2(IDLE_EFF, WAKE_TICKS),
                                 max2(max2(SETTLE_TICKS, RECFG_TICKS), POLL_TICKS));
  localparam int TW       = $clog2(MAXT + 1);

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic             tick;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             recfg_done, tmr_done, poll_done;
  logic             tmr_load, poll_load;
  logic [TW-1:0]    tmr_len, poll_len;
  pstate_e          state;
  drv_t             drv;
  logic             state_up;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  rpc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk), .rst_n (rst_sync_n), .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '0;
    else             cfg_q <= cfg_sel;
  end
  assign cfg_chg = (cfg_sel != cfg_q);

  rpc_timer #(.W(TW)) u_recfg_tmr (
    .clk (clk), .rst_n (rst_sync_n), .tick (tick),
    .load (cfg_chg), .len (TW'(RECFG_TICKS)), .done (recfg_done)
  );

  rpc_timer #(.W(TW)) u_state_tmr (
    .clk (clk), .rst_n (rst_sync_n), .tick (tick),
    .load (tmr_load), .len (tmr_len), .done (tmr_done)
  );

  rpc_timer #(.W(TW)) u_poll_tmr (
    .clk (clk), .rst_n (rst_sync_n), .tick (tick),
    .load (poll_load), .len (poll_len), .done (poll_done)
  );

  rpc_state_fsm #(
    .TW           (TW),
    .IDLE_TICKS   (IDLE_EFF),
    .WAKE_TICKS   (WAKE_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS),
    .POLL_TICKS   (POLL_TICKS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .chip_en     (chip_en),
    .sq_idle     (sq_idle),
    .lfps_det    (lfps_det),
    .rxdet_done  (rxdet_done),
    .rxdet_found (rxdet_found),
    .tmr_done    (tmr_done),
    .poll_done   (poll_done),
    .state_o     (state),
    .tmr_load    (tmr_load),
    .tmr_len     (tmr_len),
    .poll_load   (poll_load),
    .poll_len    (poll_len),
    .rxdet_req   (rxdet_req)
  );

  assign drv      = drive_of(state);
  assign dp_en    = drv.dp;
  assign cm_hold  = drv.cm;
  assign term_en  = drv.term;
  assign state_up = (state != ST_DEEP) && (state != ST_SETTLE);
  assign ready    = state_up && recfg_done;

  a_r2_pins_safe_when_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(chip_en) |=> !(dp_en || cm_hold || term_en || ready));

  a_r3_enable_blocks_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(chip_en) |=> !ready);

  a_r4_no_probe_running: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dp_en |-> !rxdet_req);

  a_r10_cfg_holds_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_chg |=> !ready);

endmodule

// File: tb/redrv_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module redrv_pwr_ctrl_tb;

  localparam int DIV = 4;
  localparam int IDL = 6;
  localparam int WK  = 2;
  localparam int ST  = 5;
  localparam int RC  = 7;
  localparam int PL  = 3;

  logic clk, rst_n, chip_en, sq_idle, lfps_det, rxdet_done, rxdet_found;
  logic [1:0] cfg_sel;
  logic dp_en, cm_hold, term_en, rxdet_req, ready;

  int n_run, n_fail;

  redrv_pwr_ctrl #(
    .TICK_DIV(DIV), .IDLE_TICKS(IDL), .IDLE_LIMIT(8), .WAKE_TICKS(WK),
    .SETTLE_TICKS(ST), .RECFG_TICKS(RC), .POLL_TICKS(PL), .CFG_W(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sq_idle(sq_idle),
    .lfps_det(lfps_det), .rxdet_done(rxdet_done), .rxdet_found(rxdet_found),
    .cfg_sel(cfg_sel), .dp_en(dp_en), .cm_hold(cm_hold), .term_en(term_en),
    .rxdet_req(rxdet_req), .ready(ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       ce;
    logic       idle;
    logic       lfps;
    logic       det;
    logic       fnd;
    logic [1:0] cfg;
    logic [7:0] wt;
    logic [3:0] exp;   // {dp_en, cm_hold, term_en, ready}
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,8'd5, 4'b0000,4'd2},  // R2 off
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'd2, 4'b0010,4'd3},  // R3 settling
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'd30,4'b0011,4'd3},  // R3 settled, unconnected
    '{1'b1,1'b1,1'b1,1'b0,1'b0,2'd0,8'd12,4'b0011,4'd7},  // R7 wake burst ignored
    '{1'b1,1'b1,1'b0,1'b1,1'b1,2'd0,8'd3, 4'b0111,4'd9},  // R9 partner found
    '{1'b1,1'b1,1'b1,1'b0,1'b0,2'd0,8'd2, 4'b0111,4'd6},  // R6 exit delay
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'd12,4'b1111,4'd6},  // R6 running
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,8'd40,4'b1111,4'd5},  // R5 busy stays
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'd10,4'b1111,4'd5},  // R5 short idle
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'd30,4'b0111,4'd5},  // R5 long idle
    '{1'b1,1'b1,1'b0,1'b1,1'b0,2'd0,8'd3, 4'b0011,4'd9},  // R9 partner lost
    '{1'b1,1'b1,1'b0,1'b1,1'b1,2'd0,8'd3, 4'b0111,4'd9},  // R9 found again
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd1,8'd3, 4'b0110,4'd10}, // R10 hold
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd1,8'd40,4'b0111,4'd10}, // R10 released
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd1,8'd2, 4'b0000,4'd2}   // R2 off again
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_rng(input string rq, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", rq, act, lo, hi);
    end
  endtask

  function automatic logic [3:0] outs();
    return {dp_en, cm_hold, term_en, ready};
  endfunction

  // count negedges until the chosen output reaches val (0: dp_en, 1: ready)
  task automatic wait_for(input int which, input logic val, input int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((((which == 0) ? dp_en : ready) !== val) && n < maxc);
  endtask

  task automatic pulse_det(input logic fnd);
    rxdet_done = 1'b1; rxdet_found = fnd;
    @(negedge clk);
    rxdet_done = 1'b0; rxdet_found = 1'b0;
  endtask

  task automatic pulse_lfps();
    lfps_det = 1'b1;
    @(negedge clk);
    lfps_det = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, reqs, dbl;
    logic prev;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; chip_en = 1'b0; sq_idle = 1'b1; lfps_det = 1'b0;
    rxdet_done = 1'b0; rxdet_found = 1'b0; cfg_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {27'd0, outs(), rxdet_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {27'd0, outs(), rxdet_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      chip_en = VEC[i].ce; sq_idle = VEC[i].idle; cfg_sel = VEC[i].cfg;
      lfps_det = VEC[i].lfps; rxdet_done = VEC[i].det; rxdet_found = VEC[i].fnd;
      @(negedge clk);
      lfps_det = 1'b0; rxdet_done = 1'b0; rxdet_found = 1'b0;
      repeat (int'(VEC[i].wt) - 1) @(negedge clk);
      chk($sformatf("R%0d row %0d", VEC[i].rq, i), {28'd0, outs()}, {28'd0, VEC[i].exp});
    end

    // R3: settle window after enable
    chip_en = 1'b1;
    wait_for(1, 1'b1, 60, n);
    chk_rng("R3 settle cycles", n, (ST - 1) * DIV, ST * DIV + 4);
    chk("R3 unconnected after settle", {28'd0, outs()}, 32'b0011);

    // R8: probe pacing while unconnected
    reqs = 0; dbl = 0; prev = 1'b0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (rxdet_req) reqs++;
      if (rxdet_req && prev) dbl++;
      prev = rxdet_req;
    end
    chk_rng("R8 probe count", reqs, 4, 7);
    chk("R8 single-cycle probes", dbl, 0);

    // R6: wake delay window
    pulse_det(1'b1);
    @(negedge clk);
    lfps_det = 1'b1;
    @(negedge clk);
    lfps_det = 1'b0;
    chk("R6 held during exit", {28'd0, outs()}, 32'b0111);
    wait_for(0, 1'b1, 40, n);
    chk_rng("R6 exit cycles", n + 1, (WK - 1) * DIV, WK * DIV + 3);

    // R4: no probe while running
    sq_idle = 1'b0;
    reqs = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (rxdet_req) reqs++;
    end
    chk("R4 no probe running", reqs, 0);
    chk("R4 running outputs", {28'd0, outs()}, 32'b1111);

    // R5: one busy cycle restarts the idle wait
    sq_idle = 1'b1;
    repeat (15) @(negedge clk);
    chk("R5 still running", dp_en, 1);
    sq_idle = 1'b0;
    @(negedge clk);
    sq_idle = 1'b1;
    wait_for(0, 1'b0, 60, n);
    chk_rng("R5 idle cycles after restart", n, (IDL - 1) * DIV, IDL * DIV + 3);
    chk("R5 connected sleep", {28'd0, outs()}, 32'b0111);

    // R7: partner loss releases bias, then wake burst ignored
    pulse_det(1'b0);
    @(negedge clk);
    chk("R7 bias released", cm_hold, 0);
    pulse_lfps();
    repeat (15) @(negedge clk);
    chk("R7 burst ignored", {28'd0, outs()}, 32'b0011);

    // R10: reconfiguration hold window
    cfg_sel = 2'd2;
    wait_for(1, 1'b0, 5, n);
    chk("R10 drop next cycle", n, 1);
    wait_for(1, 1'b1, 60, n);
    chk_rng("R10 hold cycles", n + 1, (RC - 1) * DIV, RC * DIV + 3);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", {27'd0, outs(), rxdet_req}, 32'd0);
    cfg_sel = 2'd0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 restart not ready", ready, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule